// File: doc/BRIEF.md
# Programmable Watchdog with Reset/Interrupt Steering

This block is a one-shot watchdog timer. A 16 Hz tick enable from outside drives it. Software programs an 8-bit control value. Two low bits pick a resolution of 1, 4, 16 or 64 ticks. A five-bit multiplier above them scales that resolution, and the top bit picks what happens when the timer runs out. Software keeps the timer from expiring by writing the control value again, or by reading it back. Either access reloads the full interval.

When the countdown runs out, the block sets a sticky expiry flag. The top control bit then decides the action:
- When the bit is set, the block raises a one-cycle system reset request. In the same cycle it raises a one-cycle strobe that clears a companion bit held elsewhere, and it clears its own control value.
- When the bit is clear, the block emits a single interrupt pulse instead, and the control value is kept.

After expiry the timer stays idle until software services it.

Top module: `steered_watchdog`

## Requirements
- R1: After reset the stored control value reads 0x00, the expiry flag is 0, and no reset request, interrupt or strobe is raised by ticks alone.
- R2: A serviced control value c arms a timeout of (c[6:2]) * 4^(c[1:0]) ticks. The expiry action appears in the cycle after the clock edge at which that many ticks have been counted.
- R3: A control value whose multiplier field c[6:2] is zero, including 0x00, arms nothing, and no expiry follows however many ticks arrive.
- R4: A write stores the value, which is then visible on the read-data port from the next cycle. The write also clears the expiry flag and restarts the countdown from the full interval.
- R5: A read strobe restarts the countdown from the full interval of the stored value and clears the expiry flag.
- R6: On expiry with control bit 7 set, the block raises the reset request and the companion-clear strobe together for exactly one cycle, clears the control value to 0x00, and raises no interrupt.
- R7: On expiry with control bit 7 clear, the block raises exactly one one-cycle interrupt pulse, keeps the control value, and raises no reset request.
- R8: Expiry sets the flag, and the flag stays set until the next write or read.
- R9: The countdown moves only on cycles with the tick enable high. After one expiry, no further expiry occurs until the timer is serviced.
- R10: A write or read in the same cycle as the final tick takes priority: no expiry happens, and the full interval is reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 16 Hz count enable, one cycle wide |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rd | input | 1 | Control read strobe (services the timer) |
| ctl_rdata | output | 8 | Stored control value |
| expired_flag | output | 1 | Sticky expiry flag |
| rst_req | output | 1 | One-cycle system reset request |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| century_clr | output | 1 | One-cycle strobe clearing the companion bit |

## Verification
The embedded assertions check every cycle that:
- each expiry action is a single-cycle pulse;
- a reset request always comes with a cleared control value and a set flag;
- an interrupt never comes with a reset;
- the flag stays set until software services the timer;
- no action follows a cycle without a tick.

Only the bench scenarios can show the exact tick count to expiry for different resolutions and multipliers. The same holds for the silence of disabled or unserviced one-shot timers, for the reload on a read, and for service winning over a colliding final tick.

// File: rtl/steered_watchdog.sv
module steered_watchdog #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         ctl_wr,
  input  logic [MULT_W+RES_W:0]        ctl_wdata,
  input  logic                         ctl_rd,
  output logic [MULT_W+RES_W:0]        ctl_rdata,
  output logic                         expired_flag,
  output logic                         rst_req,
  output logic                         irq_pulse,
  output logic                         century_clr
);
  localparam int CTL_W  = MULT_W + RES_W + 1;
  localparam int STEER  = CTL_W - 1;
  localparam int MAXSH  = 2 * ((1 << RES_W) - 1);
  localparam int CNT_W  = MULT_W + MAXSH;

  logic [CTL_W-1:0] ctl_q;
  logic [CNT_W-1:0] cnt;
  logic             armed;

  wire              svc      = ctl_wr | ctl_rd;
  wire [CTL_W-1:0]  src      = ctl_wr ? ctl_wdata : ctl_q;
  wire [CNT_W-1:0]  mult_ext = CNT_W'(src[STEER-1:RES_W]);
  wire [CNT_W-1:0]  load_val = mult_ext << {src[RES_W-1:0], 1'b0};
  wire              last     = armed && tick && (cnt == CNT_W'(1));

  assign ctl_rdata = ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q        <= '0;
      cnt          <= '0;
      armed        <= 1'b0;
      expired_flag <= 1'b0;
      rst_req      <= 1'b0;
      irq_pulse    <= 1'b0;
      century_clr  <= 1'b0;
    end else begin
      rst_req     <= 1'b0;
      irq_pulse   <= 1'b0;
      century_clr <= 1'b0;
      if (svc) begin
        if (ctl_wr) ctl_q <= ctl_wdata;
        expired_flag <= 1'b0;
        cnt          <= load_val;
        armed        <= (load_val != '0);
      end else if (last) begin
        armed        <= 1'b0;
        expired_flag <= 1'b1;
        if (ctl_q[STEER]) begin
          ctl_q       <= '0;
          rst_req     <= 1'b1;
          century_clr <= 1'b1;
        end else begin
          irq_pulse   <= 1'b1;
        end
      end else if (armed && tick) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  a_r6_rst_clears_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (ctl_rdata == '0) && expired_flag && !irq_pulse);
  a_r6_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req && !century_clr);
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  a_r7_irq_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> expired_flag && !rst_req);
  a_r4_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !expired_flag && (ctl_rdata == $past(ctl_wdata)) && !rst_req && !irq_pulse);
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && !ctl_wr) |=> !expired_flag && $stable(ctl_rdata) && !irq_pulse);
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_flag && !ctl_wr && !ctl_rd) |=> expired_flag);
  a_r9_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !irq_pulse && !rst_req);
endmodule

// File: tb/steered_watchdog_tb.sv
module steered_watchdog_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, ctl_wr = 1'b0, ctl_rd = 1'b0;
  logic [7:0] ctl_wdata = '0, ctl_rdata;
  logic expired_flag, rst_req, irq_pulse, century_clr;
  int total = 0, bad = 0;
  int n_irq = 0, n_rst = 0, n_clr = 0, n_pair = 0;

  always #4 clk = ~clk;

  steered_watchdog dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rd(ctl_rd), .ctl_rdata(ctl_rdata), .expired_flag(expired_flag),
    .rst_req(rst_req), .irq_pulse(irq_pulse), .century_clr(century_clr));

  always @(negedge clk) begin
    if (irq_pulse) n_irq++;
    if (rst_req) n_rst++;
    if (century_clr) n_clr++;
    if (rst_req && century_clr) n_pair++;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; #1;
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0; #1;
  endtask

  task automatic do_read();
    @(negedge clk); ctl_rd = 1'b1;
    @(negedge clk); ctl_rd = 1'b0; #1;
  endtask

  // returns tick index at which an expiry action appeared, 0 if none
  task automatic ticks_to_expiry(input int limit, output int at);
    int base = n_irq + n_rst;
    at = 0;
    for (int i = 1; i <= limit; i++) begin
      do_tick();
      if (at == 0 && (n_irq + n_rst) != base) at = i;
    end
  endtask

  task automatic t_reset();
    check("R1 ctl", ctl_rdata, 0);
    check("R1 flag", expired_flag, 0);
    for (int i = 0; i < 5; i++) do_tick();
    check("R1 no action", n_irq + n_rst + n_clr, 0);
  endtask

  task automatic t_irq_timeouts();
    int at, i0, r0;
    do_write(8'h04);
    check("R4 stored", ctl_rdata, 8'h04);
    ticks_to_expiry(4, at);
    check("R2 1 tick", at, 1);
    check("R8 flag set", expired_flag, 1);
    i0 = n_irq; r0 = n_rst;
    do_write(8'h0D);
    check("R4 write clears flag", expired_flag, 0);
    ticks_to_expiry(20, at);
    check("R2 3*4 ticks", at, 12);
    check("R7 one irq", n_irq - i0, 1);
    check("R7 no rst", n_rst - r0, 0);
    check("R7 ctl kept", ctl_rdata, 8'h0D);
    check("R9 one-shot", at, 12);
    for (int i = 0; i < 40; i++) begin @(negedge clk); end
    check("R8 flag sticky", expired_flag, 1);
    check("R9 no tick no action", n_irq - i0, 1);
  endtask

  task automatic t_reset_steer();
    int at, i0, r0, c0, p0;
    i0 = n_irq; r0 = n_rst; c0 = n_clr; p0 = n_pair;
    do_write(8'h86);
    ticks_to_expiry(20, at);
    check("R2 1*16 ticks", at, 16);
    check("R6 one rst", n_rst - r0, 1);
    check("R6 strobe with rst", n_pair - p0, 1);
    check("R6 one strobe", n_clr - c0, 1);
    check("R6 no irq", n_irq - i0, 0);
    check("R6 ctl cleared", ctl_rdata, 0);
    check("R8 flag", expired_flag, 1);
  endtask

  task automatic t_disabled();
    int at;
    do_write(8'h00);
    ticks_to_expiry(30, at);
    check("R3 zero", at, 0);
    do_write(8'h03);
    ticks_to_expiry(80, at);
    check("R3 zero multiplier", at, 0);
  endtask

  task automatic t_read_service();
    int at;
    do_write(8'h14);
    do_tick(); do_tick(); do_tick();
    do_read();
    ticks_to_expiry(10, at);
    check("R5 reload by read", at, 5);
    do_read();
    check("R5 read clears flag", expired_flag, 0);
    check("R5 ctl unchanged", ctl_rdata, 8'h14);
    ticks_to_expiry(10, at);
    check("R5 read rearms", at, 5);
  endtask

  task automatic t_collision();
    int at, base;
    do_write(8'h04);
    base = n_irq + n_rst;
    @(negedge clk); tick = 1'b1; ctl_rd = 1'b1;
    @(negedge clk); tick = 1'b0; ctl_rd = 1'b0; #1;
    check("R10 service beats tick", n_irq + n_rst - base, 0);
    ticks_to_expiry(3, at);
    check("R10 full reload", at, 1);
  endtask

  task automatic t_max();
    int at;
    do_write(8'h7F);
    ticks_to_expiry(2000, at);
    check("R2 max 31*64", at, 1984);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_irq_timeouts();
    t_reset_steer();
    t_disabled();
    t_read_service();
    t_collision();
    t_max();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule